// File: doc/BRIEF.md
# Per-Line Coherence Agent for a Directory-Based Cache

This block is the cache-side coherence engine for one processor in a system where a home directory tracks who holds each memory block. It contains a small direct-mapped cache of tags, data and per-line coherence state. It accepts CPU loads and stores and tells the CPU, through a done strobe, whether each access completed locally or needed the directory. It also accepts directory requests that downgrade or revoke a line.

Every line is Invalid, Shared (read-only) or Exclusive (read/write). A load or store that cannot complete locally is held while the agent sends a request to the home directory. The CPU stays stalled until the directory's data reply arrives. If the line chosen for a new block holds a modified copy of a different block, the modified data is written back one cycle before the request for the new block goes out. Directory requests take priority over a new CPU access in the same cycle. They are accepted while the agent is idle or waiting for a reply.

Top module: `coh_line_agent`

## Requirements
- R1: After reset every line is Invalid, no message is emitted, `cpuDone` is low, and `dirReady` is high.
- R2: A load to an Invalid line, or to a line holding another block that is not Exclusive, emits one read-miss message (`msgKind`=1) carrying the load address. When the reply arrives, `cpuDone` rises with `cpuRdata` equal to the reply data and `cpuHit` low. The line becomes Shared.
- R3: A store to an Invalid line, to a Shared line of the same block, or to a Shared line of another block emits one write-miss message (`msgKind`=2) carrying the store address. When the reply arrives, the store completes and the line becomes Exclusive holding the store data.
- R4: A load to a Shared or Exclusive line of the same block, and a store to an Exclusive line of the same block, finish in the cycle they are presented. They assert `cpuDone` and `cpuHit`, emit no message, and leave the state unchanged. A load returns the line data.
- R5: A directory invalidate (`dirKind`=1) to a Shared line of the matching block makes it Invalid without emitting a message.
- R6: A directory fetch (`dirKind`=2) to an Exclusive line of the matching block emits, in the same cycle, a write-back (`msgKind`=3) with that address and the line data. The line becomes Shared.
- R7: A directory fetch-and-invalidate (`dirKind`=3) to an Exclusive line of the matching block emits the same write-back and makes the line Invalid.
- R8: A load to an Exclusive line holding another block emits a write-back of the old block's address and data, and a read miss for the new address in the next cycle. The line ends Shared with the reply data.
- R9: A store to an Exclusive line holding another block emits a write-back of the old block, and a write miss for the new address in the next cycle. The line ends Exclusive with the store data.
- R10: During a miss, `cpuDone` stays low and no further message is emitted until `replyValid` is seen. Completion happens in the reply cycle.
- R11: A directory request whose address does not match the line's block, or whose line is in a state the request does not act on, emits nothing and leaves the line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | CPU access valid; held until `cpuDone` |
| cpuWrite | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | ADDR_W | Block address of the access |
| cpuWdata | input | DATA_W | Store data |
| cpuDone | output | 1 | Access completes this cycle |
| cpuHit | output | 1 | Completion was a local hit |
| cpuStall | output | 1 | Request pending and not completing |
| cpuRdata | output | DATA_W | Load data, valid with `cpuDone` |
| dirMsgValid | input | 1 | Directory request valid |
| dirKind | input | 2 | 1 invalidate, 2 fetch, 3 fetch-and-invalidate |
| dirAddr | input | ADDR_W | Block address of the directory request |
| dirReady | output | 1 | Directory request is accepted this cycle |
| replyValid | input | 1 | Data reply from the home directory |
| replyData | input | DATA_W | Reply data |
| msgValid | output | 1 | Outgoing message valid |
| msgKind | output | 2 | 1 read miss, 2 write miss, 3 write-back |
| msgAddr | output | ADDR_W | Block address of the message |
| msgData | output | DATA_W | Write-back data, zero otherwise |

## Verification
A wrong line state shows up at the ports on the next access to that line. A line left too permissive hits where a miss message is expected. A line left too restrictive emits a miss where `cpuHit` should rise. A dropped downgrade shows when a later fetch produces a write-back, or fails to. Ordering faults in the replacement path appear within two cycles of the access as a swapped or missing write-back. Wrong data captured at fill appears in the write-back or load value on the first later touch of the line.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2
  } lineSt_t;

  typedef enum logic [1:0] {
    MK_NONE   = 2'd0,
    MK_RDMISS = 2'd1,
    MK_WRMISS = 2'd2,
    MK_WBACK  = 2'd3
  } msgKind_t;

  typedef enum logic [1:0] {
    DK_NONE     = 2'd0,
    DK_INVAL    = 2'd1,
    DK_FETCH    = 2'd2,
    DK_FETCHINV = 2'd3
  } dirKind_t;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_VICTIM = 2'd1,
    SEL_DIRWB  = 2'd2,
    SEL_MISS   = 2'd3
  } msgSel_t;

  typedef struct packed {
    logic    latchReq;
    logic    wrHit;
    logic    victimDrop;
    logic    fill;
    logic    dirToShr;
    logic    dirToInv;
    msgSel_t msgSel;
  } ctrlStb_t;

endpackage

// File: rtl/coh_datapath.sv
module coh_datapath
  import coh_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int INDEX_W = 2,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [ADDR_W-1:0] dirAddr,
  input  logic [DATA_W-1:0] replyData,
  output logic              cpuTagHit,
  output lineSt_t           cpuLineSt,
  output logic              dirTagHit,
  output lineSt_t           dirLineSt,
  output logic              pendWrite,
  output logic [ADDR_W-1:0] msgAddr,
  output logic [DATA_W-1:0] msgData,
  output logic [DATA_W-1:0] cpuRdata
);

  localparam int LINES = 1 << INDEX_W;
  localparam int TAG_W = ADDR_W - INDEX_W;

  logic [TAG_W-1:0]  tagQ  [LINES];
  logic [DATA_W-1:0] dataQ [LINES];
  lineSt_t           stQ   [LINES];

  logic [ADDR_W-1:0] pendAddr;
  logic [DATA_W-1:0] pendWdata;

  logic [INDEX_W-1:0] cIdx, dIdx, pIdx;
  logic [TAG_W-1:0]   cTag, dTag, pTag;
  logic [DATA_W-1:0]  fillData;

  assign cIdx = cpuAddr[INDEX_W-1:0];
  assign cTag = cpuAddr[ADDR_W-1:INDEX_W];
  assign dIdx = dirAddr[INDEX_W-1:0];
  assign dTag = dirAddr[ADDR_W-1:INDEX_W];
  assign pIdx = pendAddr[INDEX_W-1:0];
  assign pTag = pendAddr[ADDR_W-1:INDEX_W];

  assign cpuTagHit = (tagQ[cIdx] == cTag);
  assign cpuLineSt = stQ[cIdx];
  assign dirTagHit = (tagQ[dIdx] == dTag);
  assign dirLineSt = stQ[dIdx];
  assign fillData  = pendWrite ? pendWdata : replyData;
  assign cpuRdata  = stb.fill ? fillData : dataQ[cIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendAddr  <= '0;
      pendWrite <= 1'b0;
      pendWdata <= '0;
    end else if (stb.latchReq) begin
      pendAddr  <= cpuAddr;
      pendWrite <= cpuWrite;
      pendWdata <= cpuWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) stQ[i] <= LS_INV;
    end else begin
      if (stb.dirToShr)   stQ[dIdx] <= LS_SHR;
      if (stb.dirToInv)   stQ[dIdx] <= LS_INV;
      if (stb.victimDrop) stQ[pIdx] <= LS_INV;
      if (stb.fill)       stQ[pIdx] <= pendWrite ? LS_EXC : LS_SHR;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.wrHit) dataQ[cIdx] <= cpuWdata;
    if (stb.fill) begin
      dataQ[pIdx] <= fillData;
      tagQ[pIdx]  <= pTag;
    end
  end

  always_comb begin
    msgAddr = '0;
    msgData = '0;
    case (stb.msgSel)
      SEL_VICTIM: begin
        msgAddr = {tagQ[pIdx], pIdx};
        msgData = dataQ[pIdx];
      end
      SEL_DIRWB: begin
        msgAddr = dirAddr;
        msgData = dataQ[dIdx];
      end
      SEL_MISS: msgAddr = pendAddr;
      default: ;
    endcase
  end

  AST_DIR_INV_APPLIED: assert property (@(posedge clk) disable iff (!rstN)
    stb.dirToInv |=> stQ[$past(dIdx)] == LS_INV);   // R5
  AST_DIR_SHR_APPLIED: assert property (@(posedge clk) disable iff (!rstN)
    stb.dirToShr |=> stQ[$past(dIdx)] == LS_SHR);   // R6
  AST_FILL_VALID: assert property (@(posedge clk) disable iff (!rstN)
    stb.fill |=> stQ[$past(pIdx)] != LS_INV);       // R2

endmodule

// File: rtl/coh_control.sv
module coh_control
  import coh_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cpuReq,
  input  logic     cpuWrite,
  input  logic     dirMsgValid,
  input  dirKind_t dirKind,
  input  logic     replyValid,
  input  logic     cpuTagHit,
  input  lineSt_t  cpuLineSt,
  input  logic     dirTagHit,
  input  lineSt_t  dirLineSt,
  input  logic     pendWrite,
  output ctrlStb_t stb,
  output logic     cpuDone,
  output logic     cpuHit,
  output logic     cpuStall,
  output logic     dirReady,
  output logic     msgValid,
  output msgKind_t msgKind
);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_MISS = 2'd2,
    ST_WAIT = 2'd3
  } phase_t;

  phase_t stateQ, stateD;
  logic   present, hitNow;

  assign dirReady = (stateQ == ST_IDLE) || (stateQ == ST_WAIT && !replyValid);
  assign present  = cpuTagHit && (cpuLineSt != LS_INV);
  assign hitNow   = present && (!cpuWrite || cpuLineSt == LS_EXC);

  always_comb begin
    stb     = '0;
    stateD  = stateQ;
    cpuDone = 1'b0;
    cpuHit  = 1'b0;

    if (dirMsgValid && dirReady && dirTagHit) begin
      case (dirKind)
        DK_INVAL: if (dirLineSt == LS_SHR) stb.dirToInv = 1'b1;
        DK_FETCH: if (dirLineSt == LS_EXC) begin
          stb.dirToShr = 1'b1;
          stb.msgSel   = SEL_DIRWB;
        end
        DK_FETCHINV: if (dirLineSt == LS_EXC) begin
          stb.dirToInv = 1'b1;
          stb.msgSel   = SEL_DIRWB;
        end
        default: ;
      endcase
    end

    case (stateQ)
      ST_IDLE: if (cpuReq && !dirMsgValid) begin
        if (hitNow) begin
          cpuDone   = 1'b1;
          cpuHit    = 1'b1;
          stb.wrHit = cpuWrite;
        end else begin
          stb.latchReq = 1'b1;
          stateD = (cpuLineSt == LS_EXC && !cpuTagHit) ? ST_WB : ST_MISS;
        end
      end
      ST_WB: begin
        stb.msgSel     = SEL_VICTIM;
        stb.victimDrop = 1'b1;
        stateD         = ST_MISS;
      end
      ST_MISS: begin
        stb.msgSel = SEL_MISS;
        stateD     = ST_WAIT;
      end
      ST_WAIT: if (replyValid) begin
        stb.fill = 1'b1;
        cpuDone  = 1'b1;
        stateD   = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign cpuStall = cpuReq && !cpuDone;
  assign msgValid = (stb.msgSel != SEL_NONE);

  always_comb begin
    case (stb.msgSel)
      SEL_VICTIM, SEL_DIRWB: msgKind = MK_WBACK;
      SEL_MISS:              msgKind = pendWrite ? MK_WRMISS : MK_RDMISS;
      default:               msgKind = MK_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  AST_WB_THEN_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WB) |=> (msgValid && msgKind != MK_WBACK));        // R8
  AST_HIT_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    cpuHit |-> !msgValid);                                             // R4
  AST_WAIT_NO_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAIT && !replyValid) |-> !cpuDone);                  // R10
  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |=> stateQ == ST_IDLE);                                    // R10
  AST_NONEXC_NO_WB: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && dirMsgValid && dirLineSt != LS_EXC)
      |-> !msgValid);                                                  // R11

endmodule

// File: rtl/coh_line_agent.sv
module coh_line_agent
  import coh_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int INDEX_W = 2,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuDone,
  output logic              cpuHit,
  output logic              cpuStall,
  output logic [DATA_W-1:0] cpuRdata,
  input  logic              dirMsgValid,
  input  logic [1:0]        dirKind,
  input  logic [ADDR_W-1:0] dirAddr,
  output logic              dirReady,
  input  logic              replyValid,
  input  logic [DATA_W-1:0] replyData,
  output logic              msgValid,
  output logic [1:0]        msgKind,
  output logic [ADDR_W-1:0] msgAddr,
  output logic [DATA_W-1:0] msgData
);

  ctrlStb_t stb;
  logic     cpuTagHit, dirTagHit, pendWrite;
  lineSt_t  cpuLineSt, dirLineSt;
  msgKind_t kindE;

  coh_control u_ctrl (
    .clk(clk), .rstN(rstN),
    .cpuReq(cpuReq), .cpuWrite(cpuWrite),
    .dirMsgValid(dirMsgValid), .dirKind(dirKind_t'(dirKind)),
    .replyValid(replyValid),
    .cpuTagHit(cpuTagHit), .cpuLineSt(cpuLineSt),
    .dirTagHit(dirTagHit), .dirLineSt(dirLineSt),
    .pendWrite(pendWrite),
    .stb(stb), .cpuDone(cpuDone), .cpuHit(cpuHit), .cpuStall(cpuStall),
    .dirReady(dirReady), .msgValid(msgValid), .msgKind(kindE)
  );

  coh_datapath #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cpuWrite(cpuWrite), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .dirAddr(dirAddr), .replyData(replyData),
    .cpuTagHit(cpuTagHit), .cpuLineSt(cpuLineSt),
    .dirTagHit(dirTagHit), .dirLineSt(dirLineSt),
    .pendWrite(pendWrite),
    .msgAddr(msgAddr), .msgData(msgData), .cpuRdata(cpuRdata)
  );

  assign msgKind = kindE;

endmodule

// File: tb/sim_coh_line_agent.sv
module sim_coh_line_agent;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cpuReq = 1'b0, cpuWrite = 1'b0;
  logic [7:0] cpuAddr = '0, cpuWdata = '0;
  logic       cpuDone, cpuHit, cpuStall;
  logic [7:0] cpuRdata;
  logic       dirMsgValid = 1'b0;
  logic [1:0] dirKind = '0;
  logic [7:0] dirAddr = '0;
  logic       dirReady;
  logic       replyValid = 1'b0;
  logic [7:0] replyData = '0;
  logic       msgValid;
  logic [1:0] msgKind;
  logic [7:0] msgAddr, msgData;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  coh_line_agent u0 (
    .clk(clk), .rstN(rstN),
    .cpuReq(cpuReq), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuDone(cpuDone), .cpuHit(cpuHit), .cpuStall(cpuStall), .cpuRdata(cpuRdata),
    .dirMsgValid(dirMsgValid), .dirKind(dirKind), .dirAddr(dirAddr),
    .dirReady(dirReady), .replyValid(replyValid), .replyData(replyData),
    .msgValid(msgValid), .msgKind(msgKind), .msgAddr(msgAddr), .msgData(msgData)
  );

  // op: 0 load, 1 store, 2 directory request (arg = dirKind)
  typedef struct packed {
    logic [1:0] op;
    logic [7:0] addr;
    logic [7:0] arg;
    logic [1:0] nMsg;
    logic [1:0] k0;
    logic [7:0] a0;
    logic [7:0] d0;
    logic [1:0] k1;
    logic [7:0] a1;
    logic       hit;
    logic [7:0] rd;
    logic [3:0] req;
  } vec_t;

  // reply data = address ^ 8'hA5; addresses 05, 09, 0D share line index 1
  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{0, 8'h05, 8'h00, 1, 1, 8'h05, 8'h00, 0, 8'h00, 0, 8'hA0, 2},  // R2 first load
    '{0, 8'h05, 8'h00, 0, 0, 8'h00, 8'h00, 0, 8'h00, 1, 8'hA0, 4},  // R4 load hit Shared
    '{1, 8'h05, 8'h33, 1, 2, 8'h05, 8'h00, 0, 8'h00, 0, 8'h00, 3},  // R3 upgrade
    '{1, 8'h05, 8'h44, 0, 0, 8'h00, 8'h00, 0, 8'h00, 1, 8'h00, 4},  // R4 store hit
    '{0, 8'h05, 8'h00, 0, 0, 8'h00, 8'h00, 0, 8'h00, 1, 8'h44, 4},  // R4 load hit Excl
    '{2, 8'h05, 8'h02, 1, 3, 8'h05, 8'h44, 0, 8'h00, 0, 8'h00, 6},  // R6 fetch
    '{0, 8'h05, 8'h00, 0, 0, 8'h00, 8'h00, 0, 8'h00, 1, 8'h44, 6},  // R6 now Shared
    '{2, 8'h09, 8'h01, 0, 0, 8'h00, 8'h00, 0, 8'h00, 0, 8'h00, 11}, // R11 tag mismatch
    '{0, 8'h05, 8'h00, 0, 0, 8'h00, 8'h00, 0, 8'h00, 1, 8'h44, 11}, // R11 line kept
    '{2, 8'h05, 8'h02, 0, 0, 8'h00, 8'h00, 0, 8'h00, 0, 8'h00, 11}, // R11 fetch on Shared
    '{2, 8'h05, 8'h01, 0, 0, 8'h00, 8'h00, 0, 8'h00, 0, 8'h00, 5},  // R5 invalidate
    '{0, 8'h05, 8'h00, 1, 1, 8'h05, 8'h00, 0, 8'h00, 0, 8'hA0, 5},  // R5 now misses
    '{1, 8'h05, 8'h55, 1, 2, 8'h05, 8'h00, 0, 8'h00, 0, 8'h00, 3},  // R3
    '{0, 8'h09, 8'h00, 2, 3, 8'h05, 8'h55, 1, 8'h09, 0, 8'hAC, 8},  // R8 replace Excl
    '{0, 8'h09, 8'h00, 0, 0, 8'h00, 8'h00, 0, 8'h00, 1, 8'hAC, 8},  // R8 ends Shared
    '{1, 8'h0D, 8'h66, 1, 2, 8'h0D, 8'h00, 0, 8'h00, 0, 8'h00, 3},  // R3 Shared other block
    '{1, 8'h09, 8'h77, 2, 3, 8'h0D, 8'h66, 2, 8'h09, 0, 8'h00, 9},  // R9 replace Excl
    '{1, 8'h09, 8'h78, 0, 0, 8'h00, 8'h00, 0, 8'h00, 1, 8'h00, 9},  // R9 ends Excl
    '{2, 8'h09, 8'h03, 1, 3, 8'h09, 8'h78, 0, 8'h00, 0, 8'h00, 7},  // R7 fetch-inv
    '{0, 8'h09, 8'h00, 1, 1, 8'h09, 8'h00, 0, 8'h00, 0, 8'hAC, 7},  // R7 now Invalid
    '{0, 8'h06, 8'h00, 1, 1, 8'h06, 8'h00, 0, 8'h00, 0, 8'hA3, 2},  // R2 other index
    '{0, 8'h09, 8'h00, 0, 0, 8'h00, 8'h00, 0, 8'h00, 1, 8'hAC, 4}   // R4 index independent
  };

  task automatic chk(input bit ok, input int req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runVec(input vec_t v, input int idx);
    int         n = 0;
    bit         seenMiss = 0;
    logic [1:0] gk [2];
    logic [7:0] ga [2];
    logic [7:0] gd [2];
    logic       gHit = 0;
    logic [7:0] gRd = 0;
    gk[0] = 0; gk[1] = 0; ga[0] = 0; ga[1] = 0; gd[0] = 0; gd[1] = 0;
    @(negedge clk);
    if (v.op == 2) begin
      dirMsgValid = 1; dirKind = v.arg[1:0]; dirAddr = v.addr;
      #2;
      chk(dirReady, int'(v.req), $sformatf("v%0d dirReady", idx), dirReady, 1);
      if (msgValid) begin gk[0] = msgKind; ga[0] = msgAddr; gd[0] = msgData; n = 1; end
      @(posedge clk);
      @(negedge clk);
      dirMsgValid = 0;
    end else begin
      cpuReq = 1; cpuWrite = v.op[0]; cpuAddr = v.addr; cpuWdata = v.arg;
      #2;
      if (cpuDone) begin
        gHit = cpuHit; gRd = cpuRdata;
        if (msgValid) n = 1;
        @(posedge clk);
      end else begin
        for (int i = 0; i < 3 && !seenMiss; i++) begin
          @(posedge clk); @(negedge clk); #2;
          if (msgValid) begin
            if (n < 2) begin gk[n] = msgKind; ga[n] = msgAddr; gd[n] = msgData; end
            n++;
            if (msgKind != 2'd3) seenMiss = 1;
          end
        end
        @(posedge clk); @(negedge clk); #2;
        // R10: waiting, nothing completes and nothing is resent
        chk(!cpuDone && !msgValid && cpuStall, 10, $sformatf("v%0d wait quiet", idx),
            {cpuDone, msgValid, cpuStall}, 3'b001);
        replyValid = 1; replyData = v.addr ^ 8'hA5;
        #2;
        chk(cpuDone, 10, $sformatf("v%0d done on reply", idx), cpuDone, 1);
        gHit = cpuHit; gRd = cpuRdata;
        @(posedge clk);
      end
      @(negedge clk);
      cpuReq = 0; replyValid = 0;
    end
    chk(n == int'(v.nMsg), int'(v.req), $sformatf("v%0d message count", idx), n, v.nMsg);
    if (v.nMsg >= 1) begin
      chk(gk[0] == v.k0, int'(v.req), $sformatf("v%0d first kind", idx), gk[0], v.k0);
      chk(ga[0] == v.a0, int'(v.req), $sformatf("v%0d first addr", idx), ga[0], v.a0);
      if (v.k0 == 2'd3)
        chk(gd[0] == v.d0, int'(v.req), $sformatf("v%0d wb data", idx), gd[0], v.d0);
    end
    if (v.nMsg == 2) begin
      chk(gk[1] == v.k1, int'(v.req), $sformatf("v%0d second kind", idx), gk[1], v.k1);
      chk(ga[1] == v.a1, int'(v.req), $sformatf("v%0d second addr", idx), ga[1], v.a1);
    end
    if (v.op != 2)
      chk(gHit == v.hit, int'(v.req), $sformatf("v%0d hit flag", idx), gHit, v.hit);
    if (v.op == 0)
      chk(gRd == v.rd, int'(v.req), $sformatf("v%0d load data", idx), gRd, v.rd);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    #2;
    // R1: reset state at the ports
    chk(!msgValid && !cpuDone && dirReady, 1, "reset outputs",
        {msgValid, cpuDone, dirReady}, 3'b001);
    for (int i = 0; i < NV; i++) runVec(VECS[i], i);

    // R10 and R11: directory request arriving while a miss waits for its reply.
    // Line 1 holds block 09 Shared; load 0D misses; invalidate of 05 must do nothing.
    @(negedge clk);
    cpuReq = 1; cpuWrite = 0; cpuAddr = 8'h0D;
    @(posedge clk); @(negedge clk);             // miss message cycle
    @(posedge clk); @(negedge clk);             // waiting
    dirMsgValid = 1; dirKind = 2'd1; dirAddr = 8'h05;
    #2;
    chk(dirReady && !msgValid && !cpuDone, 11, "dir during wait",
        {dirReady, msgValid, cpuDone}, 3'b100);
    @(posedge clk); @(negedge clk);
    dirMsgValid = 0;
    replyValid = 1; replyData = 8'hC3;
    #2;
    chk(cpuDone && cpuRdata == 8'hC3, 10, "late reply data", cpuRdata, 8'hC3);
    @(posedge clk); @(negedge clk);
    replyValid = 0; cpuReq = 0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule